// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous burst memory. A burst opens when one of two active-low start strobes, one driven by the processor and one by the cache controller, is seen low at a rising clock edge while the three chip enables select the device. The full input address is then captured. Its two low bits become the first position of a burst inside an aligned group of four words.

While no strobe is active, holding the advance input low moves the burst one position per clock. Holding advance high suspends the burst and keeps the address where it is. The order of the positions is either interleaved (exclusive-or of the start position and the step count) or linear (start position plus the step count, modulo four). The order input selects between them and is latched when the burst opens. The upper address bits never change inside a burst.

The outputs are the current array address, a flag that marks a valid access, and a flag that shows which strobe opened the burst.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and after it is released, `acc_valid` is 0, `mem_addr` is 0 and `by_ctrl` is 0 until a qualified strobe arrives.
- R2: The chip is selected when `ce1_n` is 0, `ce2` is 1 and `ce3_n` is 0 at the same edge. If `proc_start_n` is 0 at a selecting edge, then from the next cycle `mem_addr` equals the sampled `addr_in`, `acc_valid` is 1 and `by_ctrl` is 0.
- R3: If a recognised strobe is seen at an edge that does not select the chip, `acc_valid` is 0 from the next cycle.
- R4: A `ctrl_start_n` of 0 is recognised only while `proc_start_n` is 1. It then loads the address as in R2 and sets `by_ctrl` to 1. When both strobes are 0, the processor strobe wins and `by_ctrl` is 0.
- R5: While `ce1_n` is 1, a `proc_start_n` of 0 is ignored. The controller strobe is not recognised either. With `adv_n` at 1, the address and the valid flag do not change.
- R6: With `ilv_order` at 1 when the burst opens, each advance produces a low-bit pair equal to the start pair XOR the step count. For example, start 10 gives 10, 11, 00, 01.
- R7: With `ilv_order` at 0 when the burst opens, each advance adds 1 to the low-bit pair modulo 4. For example, start 01 gives 01, 10, 11, 00.
- R8: With no strobe recognised and `adv_n` at 1, `mem_addr` and `acc_valid` hold their values.
- R9: The low-bit pair wraps within its group of four after four advances. The upper 15 address bits stay fixed for as long as no new burst is loaded.
- R10: The order is taken from `ilv_order` at the opening edge. A change of `ilv_order` during the burst does not alter that burst's sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_start_n | input | 1 | Processor start strobe, active low |
| ctrl_start_n | input | 1 | Cache controller start strobe, active low |
| adv_n | input | 1 | Advance burst, active low |
| ilv_order | input | 1 | 1 selects interleaved order, 0 selects linear; drive or pull high when unused |
| ce1_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| addr_in | input | 17 | Address sampled on a qualified strobe |
| mem_addr | output | 17 | Current array word address |
| acc_valid | output | 1 | A selected burst is in progress |
| by_ctrl | output | 1 | The current burst was opened by the controller strobe |

## Verification
Bursts are opened from every start position in both orders and advanced for more than four steps. This shows the exclusive-or order apart from the modulo-four order and exposes any faulty wrap or any carry into the upper bits. Advance pulses are interleaved with suspend cycles, and the order input is toggled mid-burst, to separate stepping from holding and latched order from live order. Strobe patterns cover each single strobe, both strobes together, the processor strobe masked by the first enable, and each enable deselecting in turn. These separate the priority rule, the gating rule and the three-way select.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W  = 17,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc_start_n,
  input  logic              ctrl_start_n,
  input  logic              adv_n,
  input  logic              ilv_order,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              acc_valid,
  output logic              by_ctrl
);
  localparam int UP_W = ADDR_W - BURST_W;

  logic [UP_W-1:0]    upper_q;
  logic [BURST_W-1:0] base_q, step_q, low;
  logic               ilv_q, valid_q, src_q;

  wire chip_sel = !ce1_n && ce2 && !ce3_n;
  wire p_hit    = !proc_start_n && !ce1_n;
  wire c_hit    = !ctrl_start_n && proc_start_n;
  wire strobe   = p_hit || c_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upper_q <= '0;
      base_q  <= '0;
      step_q  <= '0;
      ilv_q   <= 1'b1;
      valid_q <= 1'b0;
      src_q   <= 1'b0;
    end else if (strobe) begin
      valid_q <= chip_sel;
      if (chip_sel) begin
        upper_q <= addr_in[ADDR_W-1:BURST_W];
        base_q  <= addr_in[BURST_W-1:0];
        step_q  <= '0;
        ilv_q   <= ilv_order;
        src_q   <= c_hit;
      end
    end else if (valid_q && !adv_n) begin
      step_q <= step_q + 1'b1;
    end
  end

  assign low       = ilv_q ? (base_q ^ step_q) : (base_q + step_q);
  assign mem_addr  = {upper_q, low};
  assign acc_valid = valid_q;
  assign by_ctrl   = src_q;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W  = 17,
  parameter int BURST_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              proc_start_n,
  input logic              ctrl_start_n,
  input logic              adv_n,
  input logic              ce1_n,
  input logic              ce2,
  input logic              ce3_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              acc_valid,
  input logic              by_ctrl
);
  logic sel_in;
  assign sel_in = !ce1_n && ce2 && !ce3_n;

  // R2
  proc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_start_n && sel_in) |=> (acc_valid && !by_ctrl && mem_addr == $past(addr_in)));

  // R4
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_start_n && !ctrl_start_n && sel_in) |=> (acc_valid && by_ctrl && mem_addr == $past(addr_in)));

  // R3
  desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((!proc_start_n && !ce1_n) || (proc_start_n && !ctrl_start_n)) && !sel_in) |=> !acc_valid);

  // R5
  ce1_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_start_n && ce1_n && adv_n) |=> ($stable(mem_addr) && $stable(acc_valid)));

  // R8
  suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_start_n && ctrl_start_n && adv_n) |=> ($stable(mem_addr) && $stable(acc_valid)));

  // R9
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_start_n && ctrl_start_n) |=> $stable(mem_addr[ADDR_W-1:BURST_W]));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .proc_start_n(proc_start_n), .ctrl_start_n(ctrl_start_n),
  .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .addr_in(addr_in),
  .mem_addr(mem_addr), .acc_valid(acc_valid), .by_ctrl(by_ctrl)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        pn = 1, cn = 1, an = 1, mode = 1, c1 = 1, c2 = 0, c3 = 1;
  logic [16:0] addr = '0;
  logic [16:0] mem_addr;
  logic        acc_valid, by_ctrl;

  int n_cmp = 0, n_bad = 0;
  int m_up = 0, m_idx = 0;
  int m_seq[4] = '{0, 0, 0, 0};
  bit m_valid = 0, m_src = 0;

  always #5 clk = ~clk;

  burst_addr_seq u_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .proc_start_n(pn), .ctrl_start_n(cn), .adv_n(an),
    .ilv_order(mode), .ce1_n(c1), .ce2(c2), .ce3_n(c3), .addr_in(addr),
    .mem_addr(mem_addr), .acc_valid(acc_valid), .by_ctrl(by_ctrl)
  );

  function automatic int ilv_pos(int s, int k);
    case (s)
      0: return (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 2 : 3;
      1: return (k == 0) ? 1 : (k == 1) ? 0 : (k == 2) ? 3 : 2;
      2: return (k == 0) ? 2 : (k == 1) ? 3 : (k == 2) ? 0 : 1;
      default: return (k == 0) ? 3 : (k == 1) ? 2 : (k == 2) ? 1 : 0;
    endcase
  endfunction

  task automatic compare(string tag);
    int exp_a = m_up * 4 + m_seq[m_idx];
    n_cmp++;
    if (mem_addr !== exp_a[16:0] || acc_valid !== m_valid || by_ctrl !== m_src) begin
      n_bad++;
      $display("FAIL %s: addr=%h valid=%0b src=%0b expected addr=%h valid=%0b src=%0b",
               tag, mem_addr, acc_valid, by_ctrl, exp_a[16:0], m_valid, m_src);
    end
  endtask

  task automatic cyc(bit p, bit c, bit a, bit md, bit e1, bit e2, bit e3,
                     logic [16:0] ad, string tag);
    bit sel, ph, ch;
    pn = p; cn = c; an = a; mode = md; c1 = e1; c2 = e2; c3 = e3; addr = ad;
    @(posedge clk);
    sel = !e1 && e2 && !e3;
    ph  = !p && !e1;
    ch  = !c && p;
    if (ph || ch) begin
      m_valid = sel;
      if (sel) begin
        m_up = int'(ad) / 4;
        for (int k = 0; k < 4; k++)
          m_seq[k] = md ? ilv_pos(int'(ad) % 4, k) : (int'(ad) % 4 + k) % 4;
        m_idx = 0;
        m_src = ch;
      end
    end else if (m_valid && !a) begin
      m_idx = (m_idx + 1) % 4;
    end
    #2;
    compare(tag);
  endtask

  task automatic open_p(bit md, logic [16:0] ad, string tag);
    cyc(0, 1, 1, md, 0, 1, 0, ad, tag);
  endtask

  task automatic adv(int n, bit md, string tag);
    for (int i = 0; i < n; i++) cyc(1, 1, 0, md, 1, 0, 1, 17'h0, tag);
  endtask

  task automatic hold(int n, string tag);
    for (int i = 0; i < n; i++) cyc(1, 1, 1, 1, 1, 0, 1, 17'h0, tag);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 compare("R1 during reset");
    @(negedge clk) rst_n = 1;
    hold(2, "R1 idle after reset");
    cyc(1, 1, 0, 1, 0, 1, 0, 17'h1FFFF, "R1 advance while idle");

    open_p(1, 17'h1ABC5, "R2 processor load");
    adv(5, 1, "R6 interleaved from 01 with wrap R9");
    open_p(1, 17'h0F0F2, "R2 load start 10");
    adv(2, 1, "R6 interleaved from 10");
    hold(3, "R8 suspend holds");
    adv(3, 1, "R6 interleaved resumes R9");
    open_p(1, 17'h12347, "R2 load start 11");
    adv(4, 1, "R6 interleaved from 11 R9");

    open_p(0, 17'h05555, "R7 linear load start 01");
    adv(5, 0, "R7 linear from 01 R9");
    open_p(0, 17'h1FFFF, "R7 linear load start 11");
    adv(2, 0, "R9 linear wrap keeps upper bits");

    open_p(1, 17'h00A41, "R10 interleaved opened");
    adv(3, 0, "R10 order latched despite mode 0");
    open_p(0, 17'h00A42, "R10 linear opened");
    adv(3, 1, "R10 order latched despite mode 1");

    cyc(1, 0, 1, 1, 0, 1, 0, 17'h13579, "R4 controller load");
    adv(2, 1, "R4 controller burst steps");
    cyc(0, 0, 1, 1, 0, 1, 0, 17'h02468, "R4 both strobes processor wins");
    cyc(1, 0, 1, 0, 0, 1, 0, 17'h0ACE3, "R4 controller load linear");

    cyc(0, 0, 1, 1, 1, 1, 0, 17'h1DEAD, "R5 processor masked by ce1");
    cyc(0, 1, 1, 1, 1, 1, 0, 17'h1BEEF, "R5 processor alone masked");
    cyc(0, 0, 0, 1, 1, 1, 0, 17'h00001, "R5 masked strobes still advance");

    cyc(1, 0, 1, 1, 0, 0, 0, 17'h11111, "R3 controller with ce2 low");
    adv(2, 1, "R3 no stepping while deselected");
    open_p(1, 17'h04444, "R2 reopen");
    cyc(0, 1, 1, 1, 0, 1, 1, 17'h03333, "R3 processor with ce3 high");
    open_p(1, 17'h04446, "R2 reopen again");
    cyc(1, 0, 1, 1, 1, 1, 0, 17'h02222, "R3 controller with ce1 high");
    hold(2, "R3 stays deselected");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule